// File: doc/BRIEF.md
# PCM Sample Register with Zero-Terminated Interrupt

This block holds the 8-bit sample that drives an audio DAC, and raises an interrupt when a zero byte reaches it. A zero is never played. It marks the end of a sample stream: the output keeps its last value, and a trip flag is set. Software leaves the trip flag set at the end of a stream, and the interrupt line follows it whenever interrupts are enabled.

Samples arrive by one of two paths, chosen by a mode bit in the control register.

- **Direct mode:** the CPU stores bytes into a data register.
- **Snoop mode:** the block watches CPU reads in a ROM window and takes the byte on the data bus. Software can then stream a sample table just by reading it.

A snooped byte is registered once and applied one cycle later. This gives the bus time to settle. Reading the control register returns the interrupt state and the mode, and also acknowledges the interrupt.

Top module: `pcm_zdac`

## Requirements
- R1: After reset, `dac_out` is 0x00, `irq_out` is 0, and a control register read returns 0x01 (interrupt enable off, snoop mode on).
- R2: A write to the control address stores bit 7 as the interrupt enable and bit 0 as the mode (0 = direct, 1 = snoop). A control read returns the mode in bit 0 and zeros in bits 6:1. When no control read is active, `reg_rdata` is 0x00 and `reg_rd_hit` is 0.
- R3: During a control read, bit 7 of `reg_rdata` equals trip AND enable, using the state before the read. After the read's clock edge, the trip flag is clear.
- R4: `irq_out` is high exactly when the trip flag and the interrupt enable are both set. A trip taken while the enable is off raises `irq_out` as soon as the enable is written to 1.
- R5: In direct mode, a nonzero write to the data address appears on `dac_out` after that clock edge and clears the trip flag.
- R6: A zero sample, from either path, leaves `dac_out` unchanged and sets the trip flag.
- R7: In snoop mode, writes to the data address change neither `dac_out` nor the trip flag.
- R8: In snoop mode, a CPU read at an address from 0x8000 to 0xBFFF inclusive captures `cpu_bus_rdata`. The captured byte takes effect, under the rules of R5 and R6, one edge after the read's edge. Reads outside the window, and window reads in direct mode, have no effect.
- R9: If a control read clears the trip flag in the same cycle that a zero sample sets it, the set wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address, qualified by the strobes |
| cpu_rd | input | 1 | Single-cycle CPU read strobe |
| cpu_wr | input | 1 | Single-cycle CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_bus_rdata | input | 8 | Byte on the CPU data bus during a read (for snooping) |
| reg_rdata | output | 8 | Control register read data, 0 when not selected |
| reg_rd_hit | output | 1 | High while a control register read is being served |
| dac_out | output | 8 | Current DAC sample |
| irq_out | output | 1 | Cartridge interrupt, trip AND enable |

## Verification
The hardest case to reach is the collision in R9, where a read-acknowledge and a zero-sample trip land on the same edge. With a single address bus, a control read and a data write can never happen in the same cycle. The collision only appears through the snoop pipeline: a window read returning 0x00 is followed at once by a control read. The bench issues exactly this back-to-back pair, with the interrupt enabled. It then checks the returned bit 7, which still shows the state before the trip, and confirms through a second control read that the flag survived.

// File: rtl/pcm_zdac_pkg.sv
package pcm_zdac_pkg;

  // Decoded, strobe-qualified bus events for one cycle.
  typedef struct packed {
    logic rd_ctrl;  // control register read
    logic wr_ctrl;  // control register write
    logic wr_data;  // data register write
    logic rd_rom;   // read inside the snoop window
  } bus_ev_t;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_SNOOP  = 1'b1
  } pcm_mode_e;

endpackage

// File: rtl/pcm_zdac_rst_sync.sv
module pcm_zdac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pcm_zdac_snoop.sv
module pcm_zdac_snoop #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] bus_byte,
  output logic              sn_val,
  output logic [DATA_W-1:0] sn_byte
);

  logic              val_q,  val_d;
  logic [DATA_W-1:0] byte_q, byte_d;

  always_comb begin
    val_d  = cap_en;
    byte_d = byte_q;
    if (cap_en) byte_d = bus_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      val_q  <= val_d;
      byte_q <= byte_d;
    end
  end

  assign sn_val  = val_q;
  assign sn_byte = byte_q;

  // R8: a captured byte is presented exactly one cycle after the capture.
  p_capture_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (sn_val && sn_byte == $past(bus_byte)));

endmodule

// File: rtl/pcm_zdac_sample.sv
module pcm_zdac_sample #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_val,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              sn_val,
  input  logic [DATA_W-1:0] sn_byte,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] dac_q,
  output logic              trip_q
);

  logic              cand_val;
  logic [DATA_W-1:0] cand_byte;
  logic              cand_zero;
  logic              trip_set, trip_clr;
  logic [DATA_W-1:0] dac_d;
  logic              dac_en;
  logic              trip_d;

  // Direct writes and snooped bytes are mutually exclusive by mode;
  // the direct path is given priority regardless.
  always_comb begin
    cand_val  = wr_val | sn_val;
    cand_byte = wr_val ? wr_byte : sn_byte;
    cand_zero = (cand_byte == '0);
    trip_set  = cand_val & cand_zero;
    trip_clr  = (cand_val & ~cand_zero) | rd_clr;
    dac_en    = cand_val & ~cand_zero;
    dac_d     = dac_en ? cand_byte : dac_q;
    if (trip_set)      trip_d = 1'b1;  // set beats read-clear
    else if (trip_clr) trip_d = 1'b0;
    else               trip_d = trip_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      dac_q  <= dac_d;
      trip_q <= trip_d;
    end
  end

  p_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_val && wr_byte == '0) |=> (dac_q == $past(dac_q) && trip_q));

  p_nonzero_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_val && wr_byte != '0) |=> (dac_q == $past(wr_byte) && !trip_q));

  p_snoop_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_val && !wr_val && sn_byte != '0) |=> (dac_q == $past(sn_byte)));

  p_trip_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && sn_val && sn_byte == '0) |=> trip_q);

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wr_val && !sn_val) |=> !trip_q);

endmodule

// File: rtl/pcm_zdac_ctrl.sv
module pcm_zdac_ctrl #(
  parameter int DATA_W   = 8,
  parameter int IRQ_BIT  = DATA_W - 1,
  parameter int MODE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              rd_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              trip,
  output logic              irq_en_q,
  output logic              mode_q,
  output logic [DATA_W-1:0] rdata
);

  import pcm_zdac_pkg::*;

  logic irq_en_d, mode_d;

  always_comb begin
    irq_en_d = irq_en_q;
    mode_d   = mode_q;
    if (wr_ctrl) begin
      irq_en_d = wdata[IRQ_BIT];
      mode_d   = wdata[MODE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      mode_q   <= MODE_SNOOP;
    end else begin
      irq_en_q <= irq_en_d;
      mode_q   <= mode_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_ctrl) begin
      rdata[IRQ_BIT]  = trip & irq_en_q;
      rdata[MODE_BIT] = mode_q;
    end
  end

  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (irq_en_q == $past(wdata[IRQ_BIT]) && mode_q == $past(wdata[MODE_BIT])));

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ($stable(irq_en_q) && $stable(mode_q)));

endmodule

// File: rtl/pcm_zdac.sv
module pcm_zdac #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] CTRL_ADDR = 16'h5010,
  parameter logic [15:0] DATA_ADDR = 16'h5011,
  parameter logic [15:0] WIN_LO    = 16'h8000,
  parameter logic [15:0] WIN_HI    = 16'hBFFF,
  parameter int          SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] cpu_bus_rdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rd_hit,
  output logic [DATA_W-1:0] dac_out,
  output logic              irq_out
);

  import pcm_zdac_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(WIN_HI);

  logic              rst_i_n;
  bus_ev_t           ev;
  logic              irq_en, mode, trip;
  logic              sn_val;
  logic [DATA_W-1:0] sn_byte;
  logic              cap_en, wr_sample;

  pcm_zdac_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    ev.rd_ctrl = cpu_rd & (cpu_addr == A_CTRL);
    ev.wr_ctrl = cpu_wr & (cpu_addr == A_CTRL);
    ev.wr_data = cpu_wr & (cpu_addr == A_DATA);
    ev.rd_rom  = cpu_rd & (cpu_addr >= A_LO) & (cpu_addr <= A_HI);
    cap_en     = ev.rd_rom  & (mode == MODE_SNOOP);
    wr_sample  = ev.wr_data & (mode == MODE_DIRECT);
  end

  pcm_zdac_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_ctrl  (ev.wr_ctrl),
    .rd_ctrl  (ev.rd_ctrl),
    .wdata    (cpu_wdata),
    .trip     (trip),
    .irq_en_q (irq_en),
    .mode_q   (mode),
    .rdata    (reg_rdata)
  );

  pcm_zdac_snoop #(.DATA_W(DATA_W)) u_snoop (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cap_en   (cap_en),
    .bus_byte (cpu_bus_rdata),
    .sn_val   (sn_val),
    .sn_byte  (sn_byte)
  );

  pcm_zdac_sample #(.DATA_W(DATA_W)) u_sample (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_val  (wr_sample),
    .wr_byte (cpu_wdata),
    .sn_val  (sn_val),
    .sn_byte (sn_byte),
    .rd_clr  (ev.rd_ctrl),
    .dac_q   (dac_out),
    .trip_q  (trip)
  );

  assign reg_rd_hit = ev.rd_ctrl;
  assign irq_out    = trip & irq_en;

  p_readmode_ignore_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode && ev.wr_data && !sn_val) |=> ($stable(dac_out) && $stable(trip)));

  p_zero_raises_irq_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_en && !ev.wr_ctrl && wr_sample && cpu_wdata == '0) |=> irq_out);

  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ev.rd_ctrl |-> (reg_rdata == '0));

endmodule

// File: tb/pcm_zdac_tb_top.sv
module pcm_zdac_tb_top;

  localparam logic [15:0] CTRL = 16'h5010;
  localparam logic [15:0] DATA = 16'h5011;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata, cpu_bus_rdata;
  logic [7:0]  reg_rdata, dac_out;
  logic        reg_rd_hit, irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_dac;
  logic       m_trip, m_en, m_mode, m_pv;
  logic [7:0] m_pd;

  always #2 clk = ~clk;

  pcm_zdac dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_bus_rdata(cpu_bus_rdata),
    .reg_rdata(reg_rdata), .reg_rd_hit(reg_rd_hit), .dac_out(dac_out),
    .irq_out(irq_out)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One bus cycle, entered and left at a falling edge.
  task automatic cyc(bit rd, bit wr, logic [15:0] a, logic [7:0] wd,
                     logic [7:0] bus, string tag);
    logic [7:0] exp_rd;
    logic       set, clr, rdc;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd; cpu_bus_rdata = bus;
    #1;
    rdc    = rd && (a == CTRL);
    exp_rd = rdc ? {m_trip & m_en, 6'b0, m_mode} : 8'h00;
    if (rdc || rd || wr) begin
      chk({tag, " rdata"}, reg_rdata, exp_rd);
      chk({tag, " rd_hit"}, {7'b0, reg_rd_hit}, {7'b0, rdc});
    end
    set = 0; clr = rdc;
    if (m_pv) begin
      if (m_pd == 0) set = 1; else begin m_dac = m_pd; clr = 1; end
    end
    if (wr && a == DATA && !m_mode) begin
      if (wd == 0) set = 1; else begin m_dac = wd; clr = 1; end
    end
    if (set) m_trip = 1; else if (clr) m_trip = 0;
    m_pv = rd && m_mode && (a >= 16'h8000) && (a <= 16'hBFFF);
    m_pd = bus;
    if (wr && a == CTRL) begin m_en = wd[7]; m_mode = wd[0]; end
    @(posedge clk); @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
    chk({tag, " dac"}, dac_out, m_dac);
    chk({tag, " irq R4"}, {7'b0, irq_out}, {7'b0, m_trip & m_en});
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 16'h0000, 8'h00, 8'h00, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cpu_rd = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0; cpu_bus_rdata = 0;
    m_dac = 0; m_trip = 0; m_en = 0; m_mode = 1; m_pv = 0; m_pd = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 dac", dac_out, 8'h00);
    chk("R1 irq", {7'b0, irq_out}, 8'h00);
    cyc(1, 0, CTRL, 8'h00, 8'h00, "R1");

    // R2 control sweep
    for (int v = 0; v < 256; v++) begin
      cyc(0, 1, CTRL, 8'(v), 8'h00, "R2");
      cyc(1, 0, CTRL, 8'h00, 8'h00, "R2");
    end

    // R5/R6 direct mode, all byte values, reads interleaved (R3)
    cyc(0, 1, CTRL, 8'h80, 8'h00, "R5");
    for (int d = 0; d < 256; d++) begin
      cyc(0, 1, DATA, 8'(d), 8'h00, (d == 0) ? "R6" : "R5");
      if (d % 16 == 0) cyc(1, 0, CTRL, 8'h00, 8'h00, "R3");
    end
    cyc(0, 1, DATA, 8'h00, 8'h00, "R6");
    cyc(1, 0, CTRL, 8'h00, 8'h00, "R3");
    cyc(1, 0, CTRL, 8'h00, 8'h00, "R3");

    // R4 enable gating
    cyc(0, 1, CTRL, 8'h00, 8'h00, "R4");
    cyc(0, 1, DATA, 8'h00, 8'h00, "R4");
    cyc(0, 1, CTRL, 8'h80, 8'h00, "R4");
    cyc(0, 1, CTRL, 8'h00, 8'h00, "R4");
    cyc(0, 1, DATA, 8'h42, 8'h00, "R4");

    // R8 window read ignored in direct mode
    cyc(1, 0, 16'h9000, 8'h00, 8'h00, "R8");
    cyc(1, 0, 16'h9000, 8'h00, 8'h99, "R8");
    idle("R8");

    // R7 data writes ignored in snoop mode
    cyc(0, 1, CTRL, 8'h81, 8'h00, "R7");
    cyc(0, 1, DATA, 8'h55, 8'h00, "R7");
    cyc(0, 1, DATA, 8'h00, 8'h00, "R7");
    idle("R7");

    // R8 snoop sweep, all byte values across the window
    for (int d = 0; d < 256; d++) begin
      cyc(1, 0, 16'h8000 + 16'(d * 64), 8'h00, 8'(255 - d), "R8");
      idle("R8");
    end
    // R8 window edges
    cyc(1, 0, 16'h7FFF, 8'h00, 8'h00, "R8"); idle("R8");
    cyc(1, 0, 16'hC000, 8'h00, 8'h00, "R8"); idle("R8");
    cyc(1, 0, 16'h7FFF, 8'h00, 8'h33, "R8"); idle("R8");
    cyc(1, 0, 16'hBFFF, 8'h00, 8'h77, "R8"); idle("R8");
    cyc(1, 0, 16'h8000, 8'h00, 8'h12, "R8"); idle("R8");
    // back-to-back snoops
    cyc(1, 0, 16'hA000, 8'h00, 8'h21, "R8");
    cyc(1, 0, 16'hA001, 8'h00, 8'h43, "R8");
    idle("R8");

    // R9 collision: zero snoop followed at once by a control read
    cyc(1, 0, 16'h8800, 8'h00, 8'h00, "R9");
    cyc(1, 0, CTRL, 8'h00, 8'h00, "R9");
    cyc(1, 0, CTRL, 8'h00, 8'h00, "R9");
    cyc(1, 0, CTRL, 8'h00, 8'h00, "R9");
    // R9 collision with nonzero snoop: clear holds
    cyc(1, 0, 16'h8801, 8'h00, 8'h00, "R9");
    idle("R9");
    cyc(1, 0, 16'h8802, 8'h00, 8'h5A, "R9");
    cyc(1, 0, CTRL, 8'h00, 8'h00, "R9");
    idle("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule